// File: doc/BRIEF.md
# Wait Timer and Loop Counter Unit

This unit serves a trigger sequencer that walks a queue of step commands. It owns two 16-bit wait timers and two 16-bit loop counters. Each of the four has its own limit register. The sequencer hands the unit one command at a time through a start strobe, an opcode, an index and a jump target. The unit answers with a one-cycle done pulse. For a conditional jump it also gives a jump-taken flag and the target.

A timer wait keeps the unit busy. The chosen timer counts up by one per clock until it equals its limit, then it clears and the unit reports done. A conditional jump compares the chosen loop counter with its limit before changing it. While they differ, the branch is taken and the counter steps up. Once they match, the command falls through and the counter returns to zero. A limit of L therefore repeats a block L+1 times in all. An add command and a copy command rewrite any limit register while the sequence runs. A host port loads limits directly. A readback mux returns either a limit or the matching live count, chosen by a visibility input.

The controller has three states. OFF is held while `enable` is low. IDLE accepts commands. TWAIT runs a timer wait. The transitions are: OFF to IDLE when enable is high; IDLE to TWAIT on a timer-wait command; TWAIT to IDLE when the count equals the limit; any state to OFF when enable is low.

Top module: `wl_timer_loop_unit`

## Requirements
- R1: After reset, `done_o` and `jump_o` are 0 and every limit and count reads back as 0, with `vis` at either value.
- R2: A timer-wait command (opcode 1; `cmd_idx[0]` picks timer 0 or 1) accepted at clock edge E0, with limit L, raises `done_o` for one cycle after edge E0+L+1. The timer reads 0 afterwards.
- R3: Readback uses `rd_sel` 0 = timer 0, 1 = timer 1, 2 = loop counter 0, 3 = loop counter 1. With `vis` = 0 it returns the limit, and with `vis` = 1 it returns the live count. During a wait, the live count after edge E0+k equals k for k from 1 to L.
- R4: A conditional jump (opcode 2; `cmd_idx[0]` picks the counter) raises `done_o` in the cycle after it is accepted. If the count differs from the limit, `jump_o` is 1, `jump_addr` equals `cmd_target` and the count rises by 1. Otherwise `jump_o` is 0 and the count goes to 0. Limit L gives L jumps, then one fall-through.
- R5: A jump on one loop counter leaves the other loop counter's count unchanged, so two loops can nest one level deep.
- R6: Add (opcode 3; `cmd_idx` 0..3 picks the limit, using the `rd_sel` encoding) stores the limit plus `adj_val`, modulo 2^16. It pulses `done_o` one cycle after it is accepted.
- R7: Copy (opcode 4; `cmd_idx` picks the limit) stores `hold_val` in the chosen limit.
- R8: When an add or copy and a host write (`host_we`) target the same limit in the same cycle, the command's value is the one kept.
- R9: While `enable` is low, all counts are 0, `done_o` and `jump_o` stay 0, and a wait in progress is abandoned without a done pulse. Limit values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable; low clears counts and idles the unit |
| cmd_start | input | 1 | Command strobe, taken in state IDLE |
| cmd_op | input | 3 | Opcode: 0 none, 1 timer wait, 2 conditional jump, 3 add, 4 copy |
| cmd_idx | input | 2 | Timer or counter select (bit 0), or limit select for add and copy |
| cmd_target | input | QW (4) | Jump destination step |
| adj_val | input | W (16) | Adjust value used by add |
| hold_val | input | W (16) | Hold value used by copy |
| host_we | input | 1 | Host write strobe for a limit register |
| host_sel | input | 2 | Host write limit select |
| host_data | input | W (16) | Host write data |
| vis | input | 1 | Readback returns live count when 1 |
| rd_sel | input | 2 | Readback select |
| rd_data | output | W (16) | Readback data |
| done_o | output | 1 | One-cycle command completion pulse |
| jump_o | output | 1 | Jump taken, valid with done_o |
| jump_addr | output | QW (4) | Jump destination, valid with jump_o |

## Verification
A timer count that slips by one moves the done pulse by one cycle. The bench sees this on the first wait, and a live readback during the wait names the cycle where the count went wrong. A loop counter that compares after it increments, or fails to clear, changes the pattern of `jump_o` within one loop period. The bench catches this by reading the count back after every jump. A limit corrupted by add, copy or write priority shows at once on `vis` = 0 readback, and it would also change the later wait length or jump count.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_TWAIT = 3'd1,
        OP_JMPC  = 3'd2,
        OP_ADD   = 3'd3,
        OP_COPY  = 3'd4
    } wl_op_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_TWAIT = 2'd2
    } wl_state_e;

    localparam int unsigned NUM_TMR  = 2;
    localparam int unsigned NUM_LOOP = 2;
    localparam int unsigned NUM_LIM  = NUM_TMR + NUM_LOOP;
endpackage

// File: rtl/wl_limit_reg.sv
module wl_limit_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [W-1:0] host_data,
    input  logic         cmd_we,
    input  logic [W-1:0] cmd_data,
    output logic [W-1:0] q
);
    // A sequencer update outranks a host write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (cmd_we)
            q <= cmd_data;
        else if (host_we)
            q <= host_data;
    end
endmodule

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         hit
);
    assign hit = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run) begin
            if (hit)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wl_loop_counter.sv
module wl_loop_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         eval,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         take
);
    // Compare first, then step or clear.
    assign take = (cnt != lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (eval) begin
            if (take)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end
endmodule

// File: rtl/wl_timer_loop_unit.sv
module wl_timer_loop_unit
    import wl_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cmd_start,
    input  logic [2:0]    cmd_op,
    input  logic [1:0]    cmd_idx,
    input  logic [QW-1:0] cmd_target,
    input  logic [W-1:0]  adj_val,
    input  logic [W-1:0]  hold_val,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [W-1:0]  host_data,
    input  logic          vis,
    input  logic [1:0]    rd_sel,
    output logic [W-1:0]  rd_data,
    output logic          done_o,
    output logic          jump_o,
    output logic [QW-1:0] jump_addr
);
    localparam int unsigned LSELW = $clog2(NUM_LIM);

    wl_state_e st_q, st_d;
    wl_op_e    op;
    logic      wsel_q;

    logic [NUM_LIM-1:0][W-1:0]  lim_q;
    logic [NUM_LIM-1:0][W-1:0]  live;
    logic [NUM_TMR-1:0][W-1:0]  tm_cnt;
    logic [NUM_TMR-1:0]         tm_hit;
    logic [NUM_LOOP-1:0][W-1:0] lc_cnt;
    logic [NUM_LOOP-1:0][W-1:0] lc_lim;
    logic [NUM_LOOP-1:0]        lc_take;

    logic accept, is_twait, is_jmp, is_upd;
    logic [W-1:0] upd_val;
    logic sel_hit, sel_take;

    assign op       = wl_op_e'(cmd_op);
    assign accept   = (st_q == ST_IDLE) && cmd_start && enable;
    assign is_twait = accept && (op == OP_TWAIT);
    assign is_jmp   = accept && (op == OP_JMPC);
    assign is_upd   = accept && ((op == OP_ADD) || (op == OP_COPY));
    assign upd_val  = (op == OP_ADD) ? (lim_q[cmd_idx] + adj_val) : hold_val;
    assign sel_hit  = tm_hit[wsel_q];
    assign sel_take = lc_take[cmd_idx[0]];

    // Limit registers: index 0,1 timers, 2,3 loop counters.
    for (genvar k = 0; k < NUM_LIM; k++) begin : g_lim
        wl_limit_reg #(.W(W)) u_lim (
            .clk      (clk),
            .rst_n    (rst_n),
            .host_we  (host_we && (host_sel == LSELW'(k))),
            .host_data(host_data),
            .cmd_we   (is_upd && (cmd_idx == LSELW'(k))),
            .cmd_data (upd_val),
            .q        (lim_q[k])
        );
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        wl_wait_timer #(.W(W)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (!enable),
            .run  ((st_q == ST_TWAIT) && (wsel_q == t[0])),
            .lim  (lim_q[t]),
            .cnt  (tm_cnt[t]),
            .hit  (tm_hit[t])
        );
        assign live[t] = tm_cnt[t];
    end

    for (genvar c = 0; c < NUM_LOOP; c++) begin : g_loop
        assign lc_lim[c] = lim_q[NUM_TMR + c];
        wl_loop_counter #(.W(W)) u_loop (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (!enable),
            .eval (is_jmp && (cmd_idx[0] == c[0])),
            .lim  (lc_lim[c]),
            .cnt  (lc_cnt[c]),
            .take (lc_take[c])
        );
        assign live[NUM_TMR + c] = lc_cnt[c];
    end

    assign rd_data = vis ? live[rd_sel] : lim_q[rd_sel];

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:   st_d = ST_IDLE;
            ST_IDLE:  if (is_twait) st_d = ST_TWAIT;
            ST_TWAIT: if (sel_hit)  st_d = ST_IDLE;
            default:  st_d = ST_OFF;
        endcase
        if (!enable) st_d = ST_OFF;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            wsel_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (is_twait) wsel_q <= cmd_idx[0];
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            jump_o    <= 1'b0;
            jump_addr <= '0;
        end else if (!enable) begin
            done_o    <= 1'b0;
            jump_o    <= 1'b0;
            jump_addr <= '0;
        end else begin
            done_o <= 1'b0;
            jump_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (is_jmp || is_upd) done_o <= 1'b1;
                    if (is_jmp && sel_take) begin
                        jump_o    <= 1'b1;
                        jump_addr <= cmd_target;
                    end
                end
                ST_TWAIT: if (sel_hit) done_o <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wl_timer_loop_checker.sv
module wl_timer_loop_checker #(
    parameter int unsigned W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cmd_start,
    input logic [2:0]        cmd_op,
    input logic [1:0]        cmd_idx,
    input logic              in_idle,
    input logic              in_wait,
    input logic              done_o,
    input logic              jump_o,
    input logic [1:0][W-1:0] tm_cnt,
    input logic [1:0][W-1:0] lc_cnt,
    input logic [1:0][W-1:0] lc_lim
);
    assert_jump_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> done_o);

    assert_jump_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && enable && cmd_start && cmd_op == 3'd2)
        |=> (jump_o == ($past(lc_cnt[cmd_idx[0]]) != $past(lc_lim[cmd_idx[0]]))));

    assert_other_counter_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && enable && cmd_start && cmd_op == 3'd2)
        |=> (lc_cnt[!$past(cmd_idx[0])] == $past(lc_cnt[!cmd_idx[0]])));

    assert_wait_end_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(in_wait)) |-> (tm_cnt == '0));

    assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!done_o && !jump_o && tm_cnt == '0 && lc_cnt == '0));
endmodule

bind wl_timer_loop_unit wl_timer_loop_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cmd_start(cmd_start),
    .cmd_op   (cmd_op),
    .cmd_idx  (cmd_idx),
    .in_idle  (st_q == wl_pkg::ST_IDLE),
    .in_wait  (st_q == wl_pkg::ST_TWAIT),
    .done_o   (done_o),
    .jump_o   (jump_o),
    .tm_cnt   (tm_cnt),
    .lc_cnt   (lc_cnt),
    .lc_lim   (lc_lim)
);

// File: tb/wl_timer_loop_unit_test.sv
module wl_timer_loop_unit_test;
    localparam int W  = 16;
    localparam int QW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cmd_start = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_idx = 2'd0;
    logic [QW-1:0] cmd_target = '0;
    logic [W-1:0]  adj_val = '0;
    logic [W-1:0]  hold_val = '0;
    logic          host_we = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic [W-1:0]  host_data = '0;
    logic          vis = 1'b0;
    logic [1:0]    rd_sel = 2'd0;
    logic [W-1:0]  rd_data;
    logic          done_o, jump_o;
    logic [QW-1:0] jump_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    wl_timer_loop_unit #(.W(W), .QW(QW)) uut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog R2: got %0d cycles expected under 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic readback(input logic v, input logic [1:0] s, output logic [W-1:0] d);
        vis = v; rd_sel = s; #0.5; d = rd_data;
    endtask

    task automatic host_write(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk); host_we = 1'b1; host_sel = s; host_data = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    // Presents a command for one edge; returns at the negedge after it.
    task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [QW-1:0] tgt);
        @(negedge clk); cmd_start = 1'b1; cmd_op = op; cmd_idx = idx; cmd_target = tgt;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        check("R1 done", done_o, 0);
        check("R1 jump", jump_o, 0);
        for (int s = 0; s < 4; s++) begin
            readback(1'b0, 2'(s), d); check("R1 limit", d, 0);
            readback(1'b1, 2'(s), d); check("R1 count", d, 0);
        end
    endtask

    task automatic t_wait(input logic sel, input logic [W-1:0] lim);
        logic [W-1:0] d;
        int k = 0;
        host_write({1'b0, sel}, lim);
        readback(1'b0, {1'b0, sel}, d); check("R3 limit readback", d, lim);
        issue(3'd1, {1'b0, sel}, '0);
        check("R2 no early done", done_o, 0);
        while (!done_o && k < 1000) begin
            @(negedge clk); k++;
            if (k <= int'(lim)) begin
                readback(1'b1, {1'b0, sel}, d); check("R3 live count", d, 32'(k));
                check("R2 still waiting", done_o, 0);
            end
        end
        check("R2 wait length", k, int'(lim) + 1);
        readback(1'b1, {1'b0, sel}, d); check("R2 timer cleared", d, 0);
        @(negedge clk); check("R2 single pulse", done_o, 0);
    endtask

    task automatic t_loop(input logic [W-1:0] lim, input logic [QW-1:0] tgt);
        logic [W-1:0] d;
        logic [W-1:0] exp_cnt = '0;
        host_write(2'd2, lim);
        for (int i = 0; i < 2 * (int'(lim) + 1); i++) begin
            logic exp_take = (exp_cnt != lim);
            issue(3'd2, 2'd0, tgt);
            check("R4 done", done_o, 1);
            check("R4 take", jump_o, exp_take);
            if (exp_take) check("R4 target", jump_addr, tgt);
            exp_cnt = exp_take ? exp_cnt + 1'b1 : '0;
            readback(1'b1, 2'd2, d); check("R4 count", d, exp_cnt);
        end
    endtask

    task automatic t_nest();
        logic [W-1:0] d;
        host_write(2'd2, 16'd3);
        host_write(2'd3, 16'd1);
        issue(3'd2, 2'd0, 4'd1);
        issue(3'd2, 2'd1, 4'd7);
        check("R5 inner take", jump_o, 1);
        readback(1'b1, 2'd2, d); check("R5 outer held", d, 1);
        readback(1'b1, 2'd3, d); check("R5 inner count", d, 1);
        issue(3'd2, 2'd1, 4'd7);
        check("R5 inner fall", jump_o, 0);
        readback(1'b1, 2'd2, d); check("R5 outer held again", d, 1);
    endtask

    task automatic t_update();
        logic [W-1:0] d;
        host_write(2'd2, 16'd2);
        adj_val = 16'd5;
        issue(3'd3, 2'd2, '0);
        check("R6 done", done_o, 1);
        readback(1'b0, 2'd2, d); check("R6 add", d, 16'd7);
        host_write(2'd1, 16'hFFFE);
        adj_val = 16'd3;
        issue(3'd3, 2'd1, '0);
        readback(1'b0, 2'd1, d); check("R6 add wraps", d, 16'h0001);
        hold_val = 16'h1234;
        issue(3'd4, 2'd0, '0);
        check("R7 done", done_o, 1);
        readback(1'b0, 2'd0, d); check("R7 copy", d, 16'h1234);
        // Same-cycle collision on limit 3.
        hold_val = 16'h0055;
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 3'd4; cmd_idx = 2'd3;
        host_we = 1'b1; host_sel = 2'd3; host_data = 16'hAAAA;
        @(negedge clk);
        cmd_start = 1'b0; host_we = 1'b0;
        readback(1'b0, 2'd3, d); check("R8 command wins", d, 16'h0055);
    endtask

    task automatic t_disable();
        logic [W-1:0] d;
        logic seen = 1'b0;
        host_write(2'd3, 16'd4);
        issue(3'd2, 2'd1, 4'd2);
        host_write(2'd0, 16'd10);
        issue(3'd1, 2'd0, '0);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9 done low", done_o, 0);
        readback(1'b1, 2'd0, d); check("R9 timer cleared", d, 0);
        readback(1'b1, 2'd3, d); check("R9 counter cleared", d, 0);
        readback(1'b0, 2'd0, d); check("R9 limit kept", d, 10);
        enable = 1'b1;
        repeat (15) begin @(negedge clk); if (done_o) seen = 1'b1; end
        check("R9 wait abandoned", seen, 0);
        readback(1'b1, 2'd0, d); check("R9 timer idle", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        repeat (2) @(negedge clk);
        t_wait(1'b0, 16'd3);
        t_wait(1'b1, 16'd0);
        t_wait(1'b1, 16'd6);
        t_loop(16'd2, 4'd5);
        t_loop(16'd0, 4'd9);
        t_nest();
        t_update();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule